// File: doc/BRIEF.md
# Configuration Capability List Walker

This block searches a function's configuration space for one capability by following the chain of capability entries link by link. It never assumes where a feature lives. It starts at the beginning of the chain and reads one dword at a time through a request/response port into an external configuration memory. It compares each entry's ID with the requested ID and moves on to the next pointer until one of four things happens: it finds a match, it reaches the end of the chain, the list turns out to be absent or empty, or it exhausts a hop budget.

Two list formats are handled, and `ext_mode` picks one when the walk starts:

- **Short-format list.** It exists only when a flag in the status word is set. The walk then begins at a head pointer held at a fixed offset.
- **Long-format list.** It always begins at byte offset 0x100.

A one-cycle `done` pulse ends every walk. The verdict (`found`, `hop_err`, `match_off`) then holds until the next accepted start.

The memory port follows valid/ready rules:

- **Request side.** The walker raises `rd_req_valid` with a dword-aligned byte offset. It holds both the valid and the offset until the memory asserts `rd_req_ready`.
- **Response side.** The walker raises `rd_rsp_ready` only while one read is outstanding. The memory must hold `rd_rsp_valid` and `rd_rsp_data` until that handshake.

The memory may stall either side for any number of cycles. Only one read is ever in flight.

Top module: `cap_walker`

## Requirements
- R1: After reset, `busy`, `done`, `found`, `hop_err` and `rd_req_valid` are all low.
- R2: In short mode the first read is byte offset 0x004. If bit 20 of that dword (status bit 4, "list present") is 0, the walk ends with found=0 and hop_err=0 after exactly one read.
- R3: In short mode the second read is byte offset 0x034. Its bits 7:0 give the head pointer with bits 1:0 forced to 0. A head of 0 ends the walk not-found, and every request offset is dword-aligned.
- R4: A short entry holds its ID in bits 7:0 and its next pointer in bits 15:8 (bits 1:0 forced to 0). Only `target_id[7:0]` is compared. On a match, `match_off` is the byte offset of that entry.
- R5: In long mode the first read is byte offset 0x100. A long entry holds its ID in bits 15:0, a version in bits 19:16 (ignored) and its next pointer in bits 31:20 (bits 1:0 forced to 0). All 16 bits of `target_id` are compared.
- R6: In long mode an all-zero dword at 0x100 means an empty list, and the walk ends not-found.
- R7: A non-matching entry whose next pointer is 0 ends the walk not-found.
- R8: Each walk may visit at most STD_HOPS (default 48) short entries or EXT_HOPS (default 960) long entries. If the last allowed entry neither matches nor ends the chain, the walk ends with hop_err=1 and found=0. A match on that last entry reports found=1 and hop_err=0.
- R9: Once raised, `rd_req_valid` and `rd_req_addr` stay unchanged until `rd_req_ready`. No new request is issued until the previous response has been accepted.
- R10: `done` is a single-cycle pulse. `found`, `hop_err` and `match_off` hold from that pulse until the next accepted start. A `start` while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| ext_mode | input | 1 | 0: short-format list, 1: long-format list |
| target_id | input | 16 | Capability ID to search for |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | 12 | Byte offset of the dword to read |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Walker accepts read data |
| rd_rsp_data | input | 32 | Read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| found | output | 1 | Matching entry located |
| hop_err | output | 1 | Hop budget exhausted |
| match_off | output | 12 | Byte offset of the matching entry |

## Verification
The delicate cycle is the one in which an ID match and hop-budget exhaustion coincide on the same response. The bench builds a short chain that fills every dword from 0x40 to 0xFC, exactly 48 entries, and places the target in the final entry. That entry is both a match and the last allowed hop, and it must report found with no error. The bench then relinks the same chain into a ring with the target removed, and the identical hop count must report an error instead. Separately, `start` is pulsed while a walk is under way, in the same cycles as stalled handshakes. The bench judges that the original target's result is reported unchanged.

// File: rtl/capw_pkg.sv
package capw_pkg;
  localparam int unsigned OFF_W  = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ID_W   = 16;

  localparam logic [OFF_W-1:0] STATUS_OFF   = 12'h004;
  localparam logic [OFF_W-1:0] HEAD_OFF     = 12'h034;
  localparam logic [OFF_W-1:0] EXT_BASE_OFF = 12'h100;
  localparam int unsigned      PRESENT_BIT  = 20;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP} walk_state_e;
  typedef enum logic [1:0] {PH_STATUS, PH_HEAD, PH_ENTRY} walk_phase_e;

  typedef struct packed {
    logic             hit;
    logic             blank;
    logic [OFF_W-1:0] next;
  } entry_view_t;
endpackage

// File: rtl/capw_entry_decode.sv
module capw_entry_decode
  import capw_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned IW = ID_W,
  parameter int unsigned AW = OFF_W
) (
  input  logic          ext,
  input  logic [DW-1:0] data,
  input  logic [IW-1:0] target,
  output entry_view_t   view
);
  localparam int unsigned SHORT_ID_W = 8;
  localparam int unsigned SHORT_NX_LO = 8;
  localparam int unsigned LONG_NX_LO  = DW - AW;

  logic          short_hit, long_hit;
  logic [AW-1:0] short_next, long_next;

  assign short_hit  = data[SHORT_ID_W-1:0] == target[SHORT_ID_W-1:0];
  assign long_hit   = data[IW-1:0] == target;
  assign short_next = {{(AW-SHORT_ID_W){1'b0}},
                       data[SHORT_NX_LO+SHORT_ID_W-1:SHORT_NX_LO+2], 2'b00};
  assign long_next  = {data[DW-1:LONG_NX_LO+2], 2'b00};

  always_comb begin
    view.blank = (data == '0);
    view.hit   = ext ? long_hit  : short_hit;
    view.next  = ext ? long_next : short_next;
  end
endmodule

// File: rtl/capw_hop_ctr.sv
module capw_hop_ctr #(
  parameter int unsigned STD_HOPS = 48,
  parameter int unsigned EXT_HOPS = 960
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic ext,
  input  logic step,
  output logic last
);
  localparam int unsigned MAXH = (STD_HOPS > EXT_HOPS) ? STD_HOPS : EXT_HOPS;
  localparam int unsigned CW   = $clog2(MAXH + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit = ext ? CW'(EXT_HOPS) : CW'(STD_HOPS);
  assign last  = (cnt == limit - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (step)   cnt <= cnt + CW'(1);
  end

  // R8
  hop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < limit);
endmodule

// File: rtl/cap_walker.sv
module cap_walker
  import capw_pkg::*;
#(
  parameter int unsigned STD_HOPS = 48,
  parameter int unsigned EXT_HOPS = 960
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ext_mode,
  input  logic [ID_W-1:0]   target_id,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [OFF_W-1:0]  rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic              hop_err,
  output logic [OFF_W-1:0]  match_off
);
  walk_state_e      state;
  walk_phase_e      phase;
  logic             ext_q;
  logic [ID_W-1:0]  tgt_q;
  logic [OFF_W-1:0] addr_q;
  logic             done_q, found_q, err_q;
  logic [OFF_W-1:0] off_q;
  entry_view_t      view;
  logic             rsp_take, accept_start, hop_step, hop_last;
  logic [OFF_W-1:0] head_ptr;

  assign rsp_take     = (state == ST_RSP) && rd_rsp_valid;
  assign accept_start = (state == ST_IDLE) && start;
  assign head_ptr     = {{(OFF_W-8){1'b0}}, rd_rsp_data[7:2], 2'b00};
  assign hop_step     = rsp_take && (phase == PH_ENTRY) && !view.hit &&
                        (view.next != '0) && !hop_last &&
                        !(ext_q && addr_q == EXT_BASE_OFF && view.blank);

  capw_entry_decode u_dec (
    .ext    (ext_q),
    .data   (rd_rsp_data),
    .target (tgt_q),
    .view   (view)
  );

  capw_hop_ctr #(.STD_HOPS(STD_HOPS), .EXT_HOPS(EXT_HOPS)) u_hops (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept_start),
    .ext   (ext_q),
    .step  (hop_step),
    .last  (hop_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      phase   <= PH_STATUS;
      ext_q   <= 1'b0;
      tgt_q   <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      found_q <= 1'b0;
      err_q   <= 1'b0;
      off_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          ext_q   <= ext_mode;
          tgt_q   <= target_id;
          found_q <= 1'b0;
          err_q   <= 1'b0;
          off_q   <= '0;
          phase   <= ext_mode ? PH_ENTRY : PH_STATUS;
          addr_q  <= ext_mode ? EXT_BASE_OFF : STATUS_OFF;
          state   <= ST_REQ;
        end
        ST_REQ: if (rd_req_ready) state <= ST_RSP;
        ST_RSP: if (rd_rsp_valid) begin
          state <= ST_REQ;
          unique case (phase)
            PH_STATUS: begin
              if (!rd_rsp_data[PRESENT_BIT]) begin
                state  <= ST_IDLE;
                done_q <= 1'b1;
              end else begin
                phase  <= PH_HEAD;
                addr_q <= HEAD_OFF;
              end
            end
            PH_HEAD: begin
              if (head_ptr == '0) begin
                state  <= ST_IDLE;
                done_q <= 1'b1;
              end else begin
                phase  <= PH_ENTRY;
                addr_q <= head_ptr;
              end
            end
            default: begin
              if (ext_q && addr_q == EXT_BASE_OFF && view.blank) begin
                state  <= ST_IDLE;
                done_q <= 1'b1;
              end else if (view.hit) begin
                state   <= ST_IDLE;
                done_q  <= 1'b1;
                found_q <= 1'b1;
                off_q   <= addr_q;
              end else if (view.next == '0) begin
                state  <= ST_IDLE;
                done_q <= 1'b1;
              end else if (hop_last) begin
                state  <= ST_IDLE;
                done_q <= 1'b1;
                err_q  <= 1'b1;
              end else begin
                addr_q <= view.next;
              end
            end
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_valid = (state == ST_REQ);
  assign rd_rsp_ready = (state == ST_RSP);
  assign rd_req_addr  = addr_q;
  assign busy         = (state != ST_IDLE);
  assign done         = done_q;
  assign found        = found_q;
  assign hop_err      = err_q;
  assign match_off    = off_q;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));
  // R9
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && rd_req_ready |=> !rd_req_valid);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(found && hop_err));
  // R3
  aligned_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> rd_req_addr[1:0] == 2'b00);
  // R10
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start && !done |=> $stable(found) && $stable(hop_err) && $stable(match_off));
endmodule

// File: tb/cap_walker_bench.sv
module cap_walker_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ext_mode = 1'b0;
  logic [15:0] target_id = '0;
  logic        rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_ready;
  logic [11:0] rd_req_addr, match_off;
  logic [31:0] rd_rsp_data;
  logic        busy, done, found, hop_err;

  logic [31:0] mem [1024];
  logic        stall_en = 1'b0;
  logic [2:0]  cyc = '0;
  logic        pend;
  logic [11:0] paddr;
  int          reads = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  int          wd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_walker u_cap_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .ext_mode(ext_mode),
    .target_id(target_id), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_data(rd_rsp_data), .busy(busy), .done(done), .found(found),
    .hop_err(hop_err), .match_off(match_off)
  );

  // memory model: optional stalls on both sides, one-cycle read latency
  assign rd_req_ready = !stall_en || (cyc[1:0] != 2'b00);
  assign rd_rsp_valid = pend && (!stall_en || cyc[0]);
  assign rd_rsp_data  = mem[paddr[11:2]];

  always_ff @(posedge clk) begin
    cyc <= cyc + 3'd1;
    if (!rst_n) begin
      pend  <= 1'b0;
      paddr <= '0;
    end else begin
      if (rd_rsp_valid && rd_rsp_ready) pend <= 1'b0;
      if (rd_req_valid && rd_req_ready) begin
        pend  <= 1'b1;
        paddr <= rd_req_addr;
        reads <= reads + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input bit ext, input logic [15:0] tgt);
    @(negedge clk);
    ext_mode  = ext;
    target_id = tgt;
    start     = 1'b1;
    reads     = 0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (done) break;
      @(negedge clk);
    end
  endtask

  task automatic verdict(input string req, input bit f, input bit e, input logic [11:0] o);
    check(done == 1'b1, req, done, 1);
    check(found == f, req, found, f);
    check(hop_err == e, req, hop_err, e);
    if (f) check(match_off == o, req, match_off, o);
  endtask

  task automatic base_image();
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    mem[12'h004 >> 2] = 32'h0010_0000;     // status bit 4 set (R2)
    mem[12'h034 >> 2] = 32'h0000_0043;     // head 0x43 -> 0x40 (R3)
    mem[12'h040 >> 2] = 32'h0000_6001;     // id 01 next 60
    mem[12'h060 >> 2] = 32'h0000_5005;     // id 05 next 50
    mem[12'h050 >> 2] = 32'h0000_0010;     // id 10 next 0
    mem[12'h100 >> 2] = 32'h1801_0001;     // id 0001 ver1 next 180
    mem[12'h180 >> 2] = 32'h2002_000B;     // id 000B next 200
    mem[12'h200 >> 2] = 32'h0003_0019;     // id 0019 next 0
  endtask

  // {ext, target[15:0], found, offset[11:0]}
  localparam logic [29:0] VEC [9] = '{
    {1'b0, 16'h0005, 1'b1, 12'h060},   // R4
    {1'b0, 16'h0010, 1'b1, 12'h050},   // R4
    {1'b0, 16'h0001, 1'b1, 12'h040},   // R3 R4
    {1'b0, 16'h0077, 1'b0, 12'h000},   // R7
    {1'b0, 16'h1205, 1'b1, 12'h060},   // R4 upper bits ignored
    {1'b1, 16'h000B, 1'b1, 12'h180},   // R5
    {1'b1, 16'h0019, 1'b1, 12'h200},   // R5
    {1'b1, 16'h0001, 1'b1, 12'h100},   // R5
    {1'b1, 16'h0105, 1'b0, 12'h000}    // R5 full width, R7
  };

  initial begin
    fork
      begin
        while (wd < 150000) begin
          @(posedge clk);
          wd++;
        end
        check(1'b0, "watchdog", wd, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    join_none

    base_image();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy, "R1", busy, 0);
    check(!done, "R1", done, 0);
    check(!found, "R1", found, 0);
    check(!hop_err, "R1", hop_err, 0);
    check(!rd_req_valid, "R1", rd_req_valid, 0);
    rst_n = 1'b1;

    for (int k = 0; k < 9; k++) begin
      stall_en = k[0];
      run(VEC[k][29], VEC[k][28:13]);
      verdict($sformatf("R4/R5/R7 vec%0d", k), VEC[k][12], 1'b0, VEC[k][11:0]);
    end
    stall_en = 1'b0;

    // R10 results hold after done
    run(1'b0, 16'h0005);
    @(negedge clk);
    check(!done, "R10", done, 0);
    repeat (3) @(negedge clk);
    check(found && match_off == 12'h060, "R10", match_off, 12'h060);

    // R10 start while busy ignored
    stall_en = 1'b1;
    @(negedge clk);
    ext_mode = 1'b0; target_id = 16'h0010; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    target_id = 16'h0001; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (done) break;
      @(negedge clk);
    end
    verdict("R10 busy start", 1'b1, 1'b0, 12'h050);
    stall_en = 1'b0;

    // R2 list absent: one read only
    mem[12'h004 >> 2] = 32'hFFEF_FFFF;
    run(1'b0, 16'h0005);
    verdict("R2", 1'b0, 1'b0, 12'h0);
    check(reads == 1, "R2 reads", reads, 1);
    mem[12'h004 >> 2] = 32'h0010_0000;

    // R3 zero head after masking
    mem[12'h034 >> 2] = 32'h0000_0003;
    run(1'b0, 16'h0003);
    verdict("R3 head zero", 1'b0, 1'b0, 12'h0);
    check(reads == 2, "R3 reads", reads, 2);

    // R6 empty long list
    mem[12'h100 >> 2] = 32'h0;
    run(1'b1, 16'h0000);
    verdict("R6", 1'b0, 1'b0, 12'h0);
    check(reads == 1, "R6 reads", reads, 1);

    // R8 long self-loop exhausts budget
    mem[12'h100 >> 2] = 32'h1001_0042;
    run(1'b1, 16'h0099);
    verdict("R8 long loop", 1'b0, 1'b1, 12'h0);
    check(reads == 960, "R8 long reads", reads, 960);

    // R8 match on last allowed hop: 48 short entries 0x40..0xFC
    mem[12'h034 >> 2] = 32'h0000_0040;
    for (int a = 12'h040; a < 12'h100; a += 4)
      mem[a >> 2] = {16'h0, 8'((a + 4) & 12'hFF), 8'h20};
    mem[12'h0FC >> 2] = 32'h0000_00AA;
    stall_en = 1'b1;
    run(1'b0, 16'h00AA);
    verdict("R8 match at limit", 1'b1, 1'b0, 12'h0FC);
    // ring without target: error at same depth
    mem[12'h0FC >> 2] = 32'h0000_4020;
    run(1'b0, 16'h00AA);
    verdict("R8 short ring", 1'b0, 1'b1, 12'h0);
    check(reads == 50, "R8 short reads", reads, 50);
    stall_en = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule